// File: doc/BRIEF.md
# Double-Width Signed Integer Divider

This block divides a signed dividend of 2W bits by a signed divisor of W bits. The dividend arrives as two W-bit halves, `num_hi` (upper) and `num_lo` (lower). The block returns a W-bit quotient and a W-bit remainder. The quotient is truncated toward zero. The remainder follows the sign of the dividend. The width W is a parameter. The intended values are 8, 16, 32 and 64. For W = 8 the whole dividend is one 16-bit value, and a caller that packs results back into that value puts the quotient in the low byte and the remainder in the high byte.

The block does not deliver results in two cases: the divisor is zero, or the exact quotient cannot be represented in W signed bits. In either case it raises a single divide-error indication. The arithmetic works on magnitudes. A restoring shift-subtract loop produces one quotient bit per clock over all 2W dividend bits. The range check runs on the unsigned quotient magnitude before the signs are applied.

The caller pulses `start` while `busy` is low. It then waits for the one-cycle `done` pulse. `quot`, `rem` and `div_err` are registered and hold their values until the next completion.

Top module: `wide_sdiv`

## Requirements
- R1: The dividend is the signed 2W-bit value {num_hi, num_lo} and the divisor is signed `den`. When no error occurs, `quot` equals the exact quotient truncated toward zero.
- R2: When no error occurs, `rem` equals dividend − quot·den. Its magnitude is strictly below that of `den`, and it is either zero or has the sign of the dividend.
- R3: When no error occurs and the quotient is nonzero, the quotient's sign bit is 1 exactly when the dividend and divisor signs differ.
- R4: A zero divisor raises `div_err` together with `done` on the first clock edge after the edge that accepted `start`. No shift-subtract iterations are run.
- R5: `div_err` is raised when the exact quotient is above 2^(W-1)−1 or below −2^(W-1). This includes the most negative dividend divided by −1. A quotient of exactly −2^(W-1) is a valid result.
- R6: Whenever `div_err` is 1, `quot` and `rem` both read zero.
- R7: With a nonzero divisor, `done` rises on the (2W+2)-th clock edge after the accepting edge. `busy` is high from the accepting edge until the edge that raises `done`.
- R8: `done` is high for exactly one cycle, and `busy` and `done` are never high at the same time.
- R9: A `start` that arrives while `busy` is high is ignored. The running operation completes with its own operands and its own latency, and no second operation follows it.
- R10: `quot`, `rem` and `div_err` change only on the edge that raises `done`. They hold their values through any input activity that does not start an operation.
- R11: After reset, `busy`, `done`, `div_err`, `quot` and `rem` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begins an operation when `busy` is low |
| num_hi | input | W | Upper half of the signed dividend |
| num_lo | input | W | Lower half of the signed dividend |
| den | input | W | Signed divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Zero divisor or quotient out of range |
| quot | output | W | Signed quotient, zero on error |
| rem | output | W | Signed remainder, zero on error |

## Verification
The hardest cases are at the edge of the quotient range. Here the magnitude reaches exactly 2^(W-1), and only the sign decides whether the result is valid or an error. Random operands almost never reach these cases, because a random upper half nearly always overflows. The directed stimulus therefore builds them explicitly at each width: the most negative dividend divided by −1, −2^(W-1) divided by 1, and +2^(W-1) divided by 1. The random tests draw the upper half mostly as the sign extension of the lower half, so that most random operations return results instead of errors.

// File: rtl/wsd_pkg.sv
`timescale 1ns/1ps
package wsd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CHECK  = 2'd1,
    ST_RUN    = 2'd2,
    ST_FINISH = 2'd3
  } wsd_state_e;
endpackage

// File: rtl/wsd_rst_sync.sv
`timescale 1ns/1ps
module wsd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/wsd_magnitude.sv
`timescale 1ns/1ps
// Splits signed operands into sign and unsigned magnitude.
module wsd_magnitude #(
  parameter int W = 32
) (
  input  logic [W-1:0]   num_hi,
  input  logic [W-1:0]   num_lo,
  input  logic [W-1:0]   den,
  output logic [2*W-1:0] dvd_mag,
  output logic [W-1:0]   den_mag,
  output logic           dvd_neg,
  output logic           den_neg
);
  localparam int DW = 2 * W;

  logic [DW-1:0] dvd_raw;

  always_comb begin
    dvd_raw = {num_hi, num_lo};
    dvd_neg = num_hi[W-1];
    den_neg = den[W-1];
    // The most negative value maps onto 2^(DW-1), which still fits unsigned.
    dvd_mag = dvd_neg ? (DW'(0) - dvd_raw) : dvd_raw;
    den_mag = den_neg ? (W'(0) - den) : den;
  end
endmodule

// File: rtl/wsd_step.sv
`timescale 1ns/1ps
// One restoring shift-subtract iteration on magnitudes.
module wsd_step #(
  parameter int W = 32
) (
  input  logic [W:0]     part,
  input  logic [2*W-1:0] qacc,
  input  logic [W-1:0]   den_mag,
  output logic [W:0]     part_nx,
  output logic [2*W-1:0] qacc_nx
);
  localparam int DW = 2 * W;

  logic [W:0] trial;
  logic [W:0] diff;
  logic       fits;

  always_comb begin
    trial   = {part[W-1:0], qacc[DW-1]};
    diff    = trial - {1'b0, den_mag};
    fits    = (trial >= {1'b0, den_mag});
    part_nx = fits ? diff : trial;
    qacc_nx = {qacc[DW-2:0], fits};
  end
endmodule

// File: rtl/wsd_finish.sv
`timescale 1ns/1ps
// Range check on the quotient magnitude, then sign application.
module wsd_finish #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] qmag,
  input  logic [W-1:0]   rmag,
  input  logic           dvd_neg,
  input  logic           den_neg,
  output logic [W-1:0]   quot,
  output logic [W-1:0]   rem,
  output logic           ovf
);
  localparam int DW = 2 * W;
  localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};

  logic         q_neg;
  logic         upper_nz;
  logic [W-1:0] low;

  always_comb begin
    q_neg    = dvd_neg ^ den_neg;
    upper_nz = |qmag[DW-1:W];
    low      = qmag[W-1:0];
    if (q_neg) ovf = upper_nz || (low > NEG_LIMIT);
    else       ovf = upper_nz || low[W-1];
    quot = q_neg   ? (W'(0) - low)  : low;
    rem  = dvd_neg ? (W'(0) - rmag) : rmag;
  end
endmodule

// File: rtl/wide_sdiv.sv
`timescale 1ns/1ps
module wide_sdiv #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num_hi,
  input  logic [W-1:0] num_lo,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic         done,
  output logic         div_err,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  import wsd_pkg::*;

  localparam int DW = 2 * W;
  localparam int CW = $clog2(DW) + 1;
  localparam logic [CW-1:0] LAST_STEP = CW'(DW - 1);

  logic rst_sync_n;

  wsd_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W:0]    part_q, part_d;
  logic [DW-1:0] qacc_q, qacc_d;
  logic [W-1:0]  dmag_q, dmag_d;
  logic          dneg_q, dneg_d;
  logic          vneg_q, vneg_d;
  logic          work_en;

  logic          done_q, done_d;
  logic          err_q, err_d;
  logic [W-1:0]  quot_q, quot_d;
  logic [W-1:0]  rem_q, rem_d;
  logic          res_en;

  logic [DW-1:0] m_dvd_mag;
  logic [W-1:0]  m_den_mag;
  logic          m_dvd_neg, m_den_neg;
  logic [W:0]    s_part;
  logic [DW-1:0] s_qacc;
  logic [W-1:0]  f_quot, f_rem;
  logic          f_ovf;

  wsd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wsd_magnitude #(.W(W)) u_mag (
    .num_hi  (num_hi),
    .num_lo  (num_lo),
    .den     (den),
    .dvd_mag (m_dvd_mag),
    .den_mag (m_den_mag),
    .dvd_neg (m_dvd_neg),
    .den_neg (m_den_neg)
  );

  wsd_step #(.W(W)) u_step (
    .part    (part_q),
    .qacc    (qacc_q),
    .den_mag (dmag_q),
    .part_nx (s_part),
    .qacc_nx (s_qacc)
  );

  wsd_finish #(.W(W)) u_fin (
    .qmag    (qacc_q),
    .rmag    (part_q[W-1:0]),
    .dvd_neg (vneg_q),
    .den_neg (dneg_q),
    .quot    (f_quot),
    .rem     (f_rem),
    .ovf     (f_ovf)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    part_d  = part_q;
    qacc_d  = qacc_q;
    dmag_d  = dmag_q;
    dneg_d  = dneg_q;
    vneg_d  = vneg_q;
    work_en = 1'b0;
    done_d  = 1'b0;
    res_en  = 1'b0;
    err_d   = err_q;
    quot_d  = quot_q;
    rem_d   = rem_q;

    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          work_en = 1'b1;
          part_d  = '0;
          qacc_d  = m_dvd_mag;
          dmag_d  = m_den_mag;
          dneg_d  = m_den_neg;
          vneg_d  = m_dvd_neg;
          state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        work_en = 1'b1;
        cnt_d   = '0;
        if (dmag_q == '0) begin
          res_en  = 1'b1;
          done_d  = 1'b1;
          err_d   = 1'b1;
          quot_d  = '0;
          rem_d   = '0;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        work_en = 1'b1;
        part_d  = s_part;
        qacc_d  = s_qacc;
        cnt_d   = cnt_q + 1'b1;
        if (cnt_q == LAST_STEP) state_d = ST_FINISH;
      end
      ST_FINISH: begin
        res_en  = 1'b1;
        done_d  = 1'b1;
        err_d   = f_ovf;
        quot_d  = f_ovf ? '0 : f_quot;
        rem_d   = f_ovf ? '0 : f_rem;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  // Datapath registers with explicit enable
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cnt_q  <= '0;
      part_q <= '0;
      qacc_q <= '0;
      dmag_q <= '0;
      dneg_q <= 1'b0;
      vneg_q <= 1'b0;
    end else if (work_en) begin
      cnt_q  <= cnt_d;
      part_q <= part_d;
      qacc_q <= qacc_d;
      dmag_q <= dmag_d;
      dneg_q <= dneg_d;
      vneg_q <= vneg_d;
    end
  end

  // Result registers, written only on completion
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      err_q  <= 1'b0;
      quot_q <= '0;
      rem_q  <= '0;
    end else if (res_en) begin
      err_q  <= err_d;
      quot_q <= quot_d;
      rem_q  <= rem_d;
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign div_err = err_q;
  assign quot    = quot_q;
  assign rem     = rem_q;
endmodule

// File: rtl/wsd_checker.sv
`timescale 1ns/1ps
module wsd_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         div_err,
  input logic [W-1:0] quot,
  input logic [W-1:0] rem,
  input logic [W-1:0] num_hi,
  input logic [W-1:0] den
);
  logic dvd_sgn_q;
  logic den_sgn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_sgn_q <= 1'b0;
      den_sgn_q <= 1'b0;
    end else if (start && !busy) begin
      dvd_sgn_q <= num_hi[W-1];
      den_sgn_q <= den[W-1];
    end
  end

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |-> (quot == '0 && rem == '0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quot) && $stable(rem) && $stable(div_err)));

  assert_zero_div_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && den == '0) |-> ##2 (done && div_err));

  assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_rem_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_err && rem != '0) |-> (rem[W-1] == dvd_sgn_q));

  assert_quot_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_err && quot != '0) |-> (quot[W-1] == (dvd_sgn_q ^ den_sgn_q)));
endmodule

bind wide_sdiv wsd_checker #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .div_err (div_err),
  .quot    (quot),
  .rem     (rem),
  .num_hi  (num_hi),
  .den     (den)
);

// File: tb/sim_wide_sdiv.sv
`timescale 1ns/1ps
module sim_wide_sdiv;
  localparam int WID [4] = '{8, 16, 32, 64};

  logic        clk;
  logic        rst_n;
  logic [3:0]  st;
  logic [63:0] hi_v [4];
  logic [63:0] lo_v [4];
  logic [63:0] dn_v [4];
  logic [63:0] q_v  [4];
  logic [63:0] r_v  [4];
  logic [3:0]  busy_v, done_v, err_v;

  int checks = 0;
  int errors = 0;

  wide_sdiv #(.W(8)) u0 (.clk(clk), .rst_n(rst_n), .start(st[0]),
    .num_hi(hi_v[0][7:0]), .num_lo(lo_v[0][7:0]), .den(dn_v[0][7:0]),
    .busy(busy_v[0]), .done(done_v[0]), .div_err(err_v[0]),
    .quot(q_v[0][7:0]), .rem(r_v[0][7:0]));
  wide_sdiv #(.W(16)) u1 (.clk(clk), .rst_n(rst_n), .start(st[1]),
    .num_hi(hi_v[1][15:0]), .num_lo(lo_v[1][15:0]), .den(dn_v[1][15:0]),
    .busy(busy_v[1]), .done(done_v[1]), .div_err(err_v[1]),
    .quot(q_v[1][15:0]), .rem(r_v[1][15:0]));
  wide_sdiv #(.W(32)) u2 (.clk(clk), .rst_n(rst_n), .start(st[2]),
    .num_hi(hi_v[2][31:0]), .num_lo(lo_v[2][31:0]), .den(dn_v[2][31:0]),
    .busy(busy_v[2]), .done(done_v[2]), .div_err(err_v[2]),
    .quot(q_v[2][31:0]), .rem(r_v[2][31:0]));
  wide_sdiv #(.W(64)) u3 (.clk(clk), .rst_n(rst_n), .start(st[3]),
    .num_hi(hi_v[3]), .num_lo(lo_v[3]), .den(dn_v[3]),
    .busy(busy_v[3]), .done(done_v[3]), .div_err(err_v[3]),
    .quot(q_v[3]), .rem(r_v[3]));

  // 125 MHz
  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [63:0] msk(input int n);
    return (n == 64) ? {64{1'b1}} : ((64'd1 << n) - 64'd1);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference: exact signed division at 132 bits
  task automatic ref_div(input int n, input logic [63:0] h, input logic [63:0] l,
                         input logic [63:0] d, output logic [63:0] q,
                         output logic [63:0] r, output logic e);
    logic [127:0] raw;
    logic signed [131:0] a, b, qq, rr, lim;
    raw = ({64'd0, h & msk(n)} << n) | {64'd0, l & msk(n)};
    a = $signed({4'd0, raw});
    a = a <<< (132 - 2 * n);
    a = a >>> (132 - 2 * n);
    b = $signed({68'd0, d & msk(n)});
    b = b <<< (132 - n);
    b = b >>> (132 - n);
    q = '0;
    r = '0;
    e = 1'b0;
    if (b == 0) begin
      e = 1'b1;
    end else begin
      qq  = a / b;
      rr  = a % b;
      lim = 132'sd1 <<< (n - 1);
      if (qq > lim - 1 || qq < -lim) e = 1'b1;
      else begin
        q = qq[63:0] & msk(n);
        r = rr[63:0] & msk(n);
      end
    end
  endtask

  task automatic do_op(input int s, input logic [63:0] h, input logic [63:0] l,
                       input logic [63:0] d, output int lat);
    @(negedge clk);
    hi_v[s] = h & msk(WID[s]);
    lo_v[s] = l & msk(WID[s]);
    dn_v[s] = d & msk(WID[s]);
    st[s] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    st[s] = 1'b0;
    lat = 0;
    while (lat < 1000) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (done_v[s]) break;
    end
  endtask

  task automatic op_check(input string tag, input int s, input logic [63:0] h,
                          input logic [63:0] l, input logic [63:0] d);
    logic [63:0] eq, er;
    logic ee;
    int lat;
    int n;
    n = WID[s];
    ref_div(n, h, l, d, eq, er, ee);
    do_op(s, h, l, d, lat);
    chk({tag, " R5 err"}, {63'd0, err_v[s]}, {63'd0, ee});
    chk({tag, " R1 quot"}, q_v[s] & msk(n), eq);
    chk({tag, " R2 rem"}, r_v[s] & msk(n), er);
    if ((d & msk(n)) == 64'd0) chk({tag, " R4 latency"}, 64'(lat), 64'd1);
    else                       chk({tag, " R7 latency"}, 64'(lat), 64'(2 * n + 2));
  endtask

  task automatic t_reset();
    for (int s = 0; s < 4; s++) begin
      chk("R11 busy", {63'd0, busy_v[s]}, 64'd0);
      chk("R11 done", {63'd0, done_v[s]}, 64'd0);
      chk("R11 err",  {63'd0, err_v[s]},  64'd0);
      chk("R11 quot", q_v[s] & msk(WID[s]), 64'd0);
      chk("R11 rem",  r_v[s] & msk(WID[s]), 64'd0);
    end
  endtask

  task automatic t_signs();
    for (int s = 0; s < 4; s++) begin
      op_check("R3 +/+", s, 64'd0, 64'd7, 64'd2);
      op_check("R3 -/+", s, {64{1'b1}}, -64'd7, 64'd2);
      op_check("R3 +/-", s, 64'd0, 64'd7, -64'd2);
      op_check("R3 -/-", s, {64{1'b1}}, -64'd7, -64'd2);
      op_check("R2 exact", s, {64{1'b1}}, -64'd12, 64'd3);
    end
  endtask

  task automatic t_zero();
    for (int s = 0; s < 4; s++) begin
      op_check("R4 zero pos", s, 64'd0, 64'd100, 64'd0);
      op_check("R4 zero neg", s, {64{1'b1}}, -64'd5, 64'd0);
      chk("R6 zero quot", q_v[s] & msk(WID[s]), 64'd0);
    end
  endtask

  task automatic t_overflow();
    logic [63:0] top;
    for (int s = 0; s < 4; s++) begin
      top = 64'd1 << (WID[s] - 1);
      op_check("R5 minneg/-1", s, top, 64'd0, {64{1'b1}});
      op_check("R5 +lim/1", s, 64'd0, top, 64'd1);
      op_check("R5 -lim/1 ok", s, {64{1'b1}}, top, 64'd1);
      op_check("R5 -lim/-1", s, {64{1'b1}}, top, {64{1'b1}});
      op_check("R5 hi/1", s, 64'd1, 64'd0, 64'd1);
      chk("R6 ovf rem", r_v[s] & msk(WID[s]), 64'd0);
    end
  endtask

  task automatic t_random();
    logic [63:0] h, l, d;
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 24; i++) begin
        l = {$urandom, $urandom};
        d = {$urandom, $urandom};
        if (i % 4 == 3) h = {$urandom, $urandom};
        else h = l[WID[s] - 1] ? {64{1'b1}} : 64'd0;
        if (i % 5 == 0) d = d >> (WID[s] / 2);
        op_check("R1 random", s, h, l, d);
      end
    end
  endtask

  task automatic t_busy_ignore();
    logic [63:0] eq, er;
    logic ee;
    int lat;
    ref_div(16, 64'd0, 64'd1000, 64'd7, eq, er, ee);
    @(negedge clk);
    hi_v[1] = 64'd0; lo_v[1] = 64'd1000; dn_v[1] = 64'd7;
    st[1] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    st[1] = 1'b0;
    lat = 0;
    while (lat < 1000) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (done_v[1]) break;
      if (lat == 3) begin
        lo_v[1] = 64'd50; dn_v[1] = 64'd0; st[1] = 1'b1;
      end else begin
        st[1] = 1'b0;
      end
    end
    chk("R9 latency", 64'(lat), 64'd34);
    chk("R9 quot", q_v[1] & 64'hFFFF, eq);
    chk("R9 rem", r_v[1] & 64'hFFFF, er);
    chk("R9 err", {63'd0, err_v[1]}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 no second op", {63'd0, busy_v[1]}, 64'd0);
  endtask

  task automatic t_hold();
    logic [63:0] q0, r0;
    op_check("R10 setup", 2, 64'd0, 64'd12345, 64'd11);
    q0 = q_v[2];
    r0 = r_v[2];
    @(posedge clk);
    @(negedge clk);
    chk("R8 done pulse", {63'd0, done_v[2]}, 64'd0);
    for (int i = 0; i < 8; i++) begin
      hi_v[2] = {$urandom, $urandom};
      lo_v[2] = {$urandom, $urandom};
      dn_v[2] = 64'd0;
      @(posedge clk);
      @(negedge clk);
    end
    chk("R10 quot held", q_v[2] & msk(32), q0 & msk(32));
    chk("R10 rem held", r_v[2] & msk(32), r0 & msk(32));
    chk("R10 err held", {63'd0, err_v[2]}, 64'd0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    st = '0;
    for (int s = 0; s < 4; s++) begin
      hi_v[s] = '0; lo_v[s] = '0; dn_v[s] = '0;
    end
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_signs();
    t_zero();
    t_overflow();
    t_random();
    t_busy_ignore();
    t_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule